// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block turns the two phase outputs of an incremental encoder into a 16-bit position. Each raw channel arrives asynchronously to the clock. It passes through a two-flop synchronizer and then a level filter that accepts a new level only after three consecutive equal samples. The filtered pair feeds a decoder that compares the previous two-bit state with the present one. Every state change yields one count at four counts per encoder cycle, and the direction follows the phase order. The counts drive a wrapping up/down counter.

Software reads the position through a byte-wide port. A holding register normally follows the counter. While the active-low read request `rd_n` is held low, the register freezes, so the high and low bytes of one read belong to the same sample. The counter keeps counting underneath.

The read port has a valid flag and no ready. The consumer paces the transfer with `rd_n` alone: data is valid and stable for as long as `rd_n` stays low, so there is nothing to back-pressure. A debug count pulse and a direction bit are brought out as well.

Top module: `quad_pos_counter`

## Requirements
- R1: A channel level change is counted only after the synchronized input has held the new level for three consecutive rising edges. A pulse lasting one or two clock periods produces no count pulse and leaves the position unchanged.
- R2: With the filtered state written as {A,B}, each step of the sequence 00, 10, 11, 01, 00 adds one to the position, and `cnt_up` is 1 during the count pulse.
- R3: Each step of the reverse sequence 00, 01, 11, 10, 00 subtracts one from the position, and `cnt_up` is 0 during the count pulse.
- R4: A change of both filtered channels in the same cycle (00 to 11, 11 to 00, 10 to 01 or 01 to 10) is counted as one step up.
- R5: The position wraps modulo 65536: one step down from 0 gives 0xFFFF, and one step up from 0xFFFF gives 0.
- R6: Suppose a single channel changes just before rising edge 1 and is then held. `cnt_pulse` is high for one cycle after edge 6, and the counter holds the new value after edge 7.
- R7: Two filtered state changes one clock period apart are both counted.
- R8: A low level on `rst_n` clears the counter, the filters, the decoder state and the holding register at once, without waiting for a clock edge. After release with the channels at 00, the position reads 0.
- R9: While `rd_n` is low, `rd_valid` is 1. `rd_sel`=0 returns bits 15:8 of the holding register and `rd_sel`=1 returns bits 7:0. While `rd_n` is high, `rd_valid` is 0 and `rd_data` is 0.
- R10: At each rising edge that samples `rd_n` high, the holding register loads the counter. At each edge that samples `rd_n` low, it keeps its value while the counter goes on counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enc_a | input | 1 | Raw encoder phase A, asynchronous |
| enc_b | input | 1 | Raw encoder phase B, asynchronous |
| rd_sel | input | 1 | Byte select: 0 high byte, 1 low byte |
| rd_n | input | 1 | Active-low read request; freezes the holding register |
| rd_data | output | 8 | Selected byte of the held position, 0 when not reading |
| rd_valid | output | 1 | High while rd_n is low |
| cnt_pulse | output | 1 | One-cycle pulse per decoded step |
| cnt_up | output | 1 | Direction of the current step, 1 for up |

## Verification
The assertions assume that `rd_n` and `rd_sel` are synchronous to `clk`, and that the channels are already at 00 when reset is released, so that no step is decoded at start-up. The bench drives every input just after a falling edge and always starts from reset with both channels low. Each encoder state is held for four clock periods, except where a test deliberately shortens it to probe the filter, or offsets the two channels by one cycle to probe back-to-back steps.

// File: rtl/qpc_pkg.sv
`timescale 1ns/1ps
package qpc_pkg;

  typedef struct packed {
    logic a;
    logic b;
  } ab_t;

  // position of a filtered {A,B} state along the up-counting cycle
  function automatic logic [1:0] phase_of(ab_t s);
    logic [1:0] p;
    case ({s.a, s.b})
      2'b00:   p = 2'd0;
      2'b10:   p = 2'd1;
      2'b11:   p = 2'd2;
      default: p = 2'd3;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/qpc_chan_filter.sv
`timescale 1ns/1ps
module qpc_chan_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [FILT_DEPTH-1:0]  hist_q;
  logic                   filt_q;
  logic                   synced;

  assign synced = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      hist_q <= '0;
      filt_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
      hist_q <= {hist_q[FILT_DEPTH-2:0], synced};
      if (&hist_q)
        filt_q <= 1'b1;
      else if (~|hist_q)
        filt_q <= 1'b0;
    end
  end

  assign filt = filt_q;

endmodule

// File: rtl/qpc_decoder.sv
`timescale 1ns/1ps
module qpc_decoder
  import qpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  ab_t  cur,
  output logic step,
  output logic up
);

  ab_t        prev_q;
  logic [1:0] ph_cur;
  logic [1:0] ph_prev;
  logic [1:0] delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  always_comb begin
    ph_cur  = phase_of(cur);
    ph_prev = phase_of(prev_q);
    delta   = ph_cur - ph_prev;
    step    = (cur != prev_q);
    // +1 forward, +2 (both channels moved) treated as forward, +3 backward
    up      = (delta != 2'd3);
  end

endmodule

// File: rtl/qpc_count_latch.sv
`timescale 1ns/1ps
module qpc_count_latch #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8,
  localparam int NB    = CNT_W / BUS_W,
  localparam int SEL_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             up,
  input  logic             rd_n,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] count_o,
  output logic [CNT_W-1:0] latch_o,
  output logic [BUS_W-1:0] data_o,
  output logic             valid_o
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] latch_q;
  logic [BUS_W-1:0] lanes [NB];
  logic [SEL_W-1:0] lane_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (step) begin
      if (up) count_q <= count_q + CNT_W'(1);
      else    count_q <= count_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    latch_q <= '0;
    else if (rd_n) latch_q <= count_q;
  end

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign lanes[g] = latch_q[g*BUS_W +: BUS_W];
  end

  // select 0 addresses the most significant lane
  assign lane_idx = SEL_W'(NB - 1) - sel;
  assign data_o   = rd_n ? '0 : lanes[lane_idx];
  assign valid_o  = ~rd_n;
  assign count_o  = count_q;
  assign latch_o  = latch_q;

endmodule

// File: rtl/quad_pos_counter.sv
`timescale 1ns/1ps
module quad_pos_counter
  import qpc_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int BUS_W       = 8,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_DEPTH  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enc_a,
  input  logic             enc_b,
  input  logic             rd_sel,
  input  logic             rd_n,
  output logic [BUS_W-1:0] rd_data,
  output logic             rd_valid,
  output logic             cnt_pulse,
  output logic             cnt_up
);

  localparam int NCH = 2;

  logic [NCH-1:0]   raw_ab;
  logic [NCH-1:0]   filt_ab;
  ab_t              cur_ab;
  logic             step_w;
  logic             up_w;
  logic [CNT_W-1:0] count_w;
  logic [CNT_W-1:0] latch_w;

  assign raw_ab = {enc_a, enc_b};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    qpc_chan_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_DEPTH (FILT_DEPTH)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_ab[c]),
      .filt (filt_ab[c])
    );
  end

  assign cur_ab.a = filt_ab[1];
  assign cur_ab.b = filt_ab[0];

  qpc_decoder u_dec (
    .clk  (clk),
    .rst_n(rst_n),
    .cur  (cur_ab),
    .step (step_w),
    .up   (up_w)
  );

  qpc_count_latch #(
    .CNT_W(CNT_W),
    .BUS_W(BUS_W)
  ) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step_w),
    .up     (up_w),
    .rd_n   (rd_n),
    .sel    (rd_sel),
    .count_o(count_w),
    .latch_o(latch_w),
    .data_o (rd_data),
    .valid_o(rd_valid)
  );

  assign cnt_pulse = step_w;
  assign cnt_up    = up_w;

endmodule

// File: rtl/qpc_checker.sv
`timescale 1ns/1ps
module qpc_checker #(
  parameter int CNT_W = 16,
  parameter int BUS_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pulse,
  input logic             up,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] latch,
  input logic             rd_n,
  input logic             rd_valid,
  input logic [BUS_W-1:0] rd_data
);

  p_step_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && up) |=> (count == $past(count) + CNT_W'(1)));

  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse && !up) |=> (count == $past(count) - CNT_W'(1)));

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |=> $stable(count));

  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |=> $stable(latch));

  p_track_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |=> (latch == $past(count)));

  p_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid == !rd_n);

  p_idle_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> (rd_data == '0));

endmodule

bind quad_pos_counter qpc_checker #(
  .CNT_W(CNT_W),
  .BUS_W(BUS_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .pulse   (cnt_pulse),
  .up      (cnt_up),
  .count   (count_w),
  .latch   (latch_w),
  .rd_n    (rd_n),
  .rd_valid(rd_valid),
  .rd_data (rd_data)
);

// File: tb/sim_quad_pos_counter.sv
`timescale 1ns/1ps
module sim_quad_pos_counter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enc_a = 1'b0;
  logic       enc_b = 1'b0;
  logic       rd_sel = 1'b0;
  logic       rd_n = 1'b1;
  logic [7:0] rd_data;
  logic       rd_valid;
  logic       cnt_pulse;
  logic       cnt_up;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 0;

  logic [15:0] exp_pos = '0;
  int          idx = 0;

  always #2 clk = ~clk;

  quad_pos_counter u0 (
    .clk(clk), .rst_n(rst_n), .enc_a(enc_a), .enc_b(enc_b),
    .rd_sel(rd_sel), .rd_n(rd_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .cnt_pulse(cnt_pulse), .cnt_up(cnt_up)
  );

  always @(negedge clk) if (rst_n && cnt_pulse) pulses++;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // {A,B} for a phase index: 0->00, 1->10, 2->11, 3->01
  task automatic drive_phase(int p);
    enc_a = (p == 1 || p == 2);
    enc_b = (p == 2 || p == 3);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(bit fwd);
    @(negedge clk);
    idx = fwd ? (idx + 1) % 4 : (idx + 3) % 4;
    exp_pos = fwd ? exp_pos + 16'd1 : exp_pos - 16'd1;
    drive_phase(idx);
    settle(3);
  endtask

  // read both bytes in one low phase of rd_n, then release
  task automatic read_pos(output logic [15:0] v, input string req);
    @(negedge clk);
    rd_n = 1'b0; rd_sel = 1'b0;
    #1 v[15:8] = rd_data;
    check({req, " valid"}, rd_valid, 1);
    rd_sel = 1'b1;
    #1 v[7:0] = rd_data;
    @(negedge clk);
    rd_n = 1'b1;
  endtask

  task automatic expect_pos(string req);
    logic [15:0] v;
    settle(9);
    read_pos(v, req);
    check(req, v, exp_pos);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, snap;
    int first, p0;
    bit dir_seen;

    // R8, R9: reset state
    settle(3);
    #1 check("R9 idle valid", rd_valid, 0);
    check("R9 idle data", rd_data, 0);
    @(negedge clk) rst_n = 1'b1;
    expect_pos("R8 after reset");

    // R2: forward sweep
    for (int i = 0; i < 20; i++) begin
      step(1'b1);
      expect_pos("R2 forward");
    end

    // R3, R5: reverse through zero
    for (int i = 0; i < 30; i++) begin
      step(1'b0);
      if (i % 3 == 0 || exp_pos >= 16'hFFFE || exp_pos <= 16'd1)
        expect_pos(exp_pos > 16'h8000 ? "R5 underflow wrap" : "R3 reverse");
    end
    // R5: forward back across 0xFFFF -> 0
    for (int i = 0; i < 15; i++) begin
      step(1'b1);
      if (exp_pos <= 16'd1 || exp_pos == 16'hFFFF) expect_pos("R5 overflow wrap");
    end
    expect_pos("R2 forward");

    // R6: latency and direction from a settled state
    settle(6);
    first = 0; dir_seen = 0;
    @(negedge clk);
    idx = (idx + 1) % 4; exp_pos = exp_pos + 16'd1;
    drive_phase(idx);
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      #0.5;
      if (cnt_pulse && first == 0) begin first = k; dir_seen = cnt_up; end
    end
    check("R6 pulse edge", first, 6);
    check("R2 up dir", dir_seen, 1);
    @(negedge clk);
    rd_n = 1'b0; rd_sel = 1'b0;
    #1 v[15:8] = rd_data; rd_sel = 1'b1;
    #1 v[7:0] = rd_data;
    @(negedge clk) rd_n = 1'b1;
    check("R6 count by edge 7", v, exp_pos);

    // R3 direction bit
    settle(4);
    first = 0;
    @(negedge clk);
    idx = (idx + 3) % 4; exp_pos = exp_pos - 16'd1;
    drive_phase(idx);
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      #0.5;
      if (cnt_pulse && first == 0) begin first = k; dir_seen = cnt_up; end
    end
    check("R3 down dir", dir_seen, 0);
    expect_pos("R3 reverse");

    // R7: channels one cycle apart, from a phase-0 state
    while (idx != 0) step(1'b1);
    expect_pos("R2 forward");
    p0 = pulses;
    @(negedge clk) enc_a = 1'b1;
    @(negedge clk) enc_b = 1'b1;
    idx = 2; exp_pos = exp_pos + 16'd2;
    expect_pos("R7 back-to-back");
    check("R7 pulses", pulses - p0, 2);

    // R4: both channels at once
    @(negedge clk) begin enc_a = 1'b0; enc_b = 1'b0; end
    idx = 0; exp_pos = exp_pos + 16'd1;
    expect_pos("R4 11 to 00");
    @(negedge clk) begin enc_a = 1'b1; enc_b = 1'b1; end
    idx = 2; exp_pos = exp_pos + 16'd1;
    expect_pos("R4 00 to 11");
    step(1'b0);
    expect_pos("R3 reverse");
    @(negedge clk) begin enc_a = 1'b0; enc_b = 1'b1; end
    idx = 3; exp_pos = exp_pos + 16'd1;
    expect_pos("R4 10 to 01");
    step(1'b1);
    expect_pos("R2 forward");

    // R1: short pulses rejected, three cycles accepted
    for (int w = 1; w <= 2; w++) begin
      p0 = pulses;
      @(negedge clk) enc_b = 1'b1;
      settle(w);
      enc_b = 1'b0;
      expect_pos("R1 glitch rejected");
      check("R1 glitch no pulse", pulses - p0, 0);
    end
    p0 = pulses;
    @(negedge clk) enc_b = 1'b1;
    settle(3);
    enc_b = 1'b0;
    expect_pos("R1 three-cycle pulse net");
    check("R1 three-cycle accepted", pulses - p0, 2);

    // R10: freeze during read, counter keeps going
    settle(4);
    @(negedge clk);
    rd_n = 1'b0; rd_sel = 1'b0;
    #1 snap[15:8] = rd_data; rd_sel = 1'b1;
    #1 snap[7:0] = rd_data;
    check("R10 snapshot", snap, exp_pos);
    for (int i = 0; i < 5; i++) step(1'b1);
    settle(9);
    rd_sel = 1'b0;
    #1 v[15:8] = rd_data; rd_sel = 1'b1;
    #1 v[7:0] = rd_data;
    check("R10 frozen", v, snap);
    check("R9 valid while held", rd_valid, 1);
    @(negedge clk) rd_n = 1'b1;
    #1 check("R9 data zero when idle", rd_data, 0);
    expect_pos("R10 resumes tracking");

    // R9: lane order on a value with distinct bytes
    for (int i = 0; i < 3; i++) step(1'b1);
    settle(9);
    @(negedge clk);
    rd_n = 1'b0; rd_sel = 1'b1;
    #1 check("R9 low byte", rd_data, exp_pos[7:0]);
    rd_sel = 1'b0;
    #1 check("R9 high byte", rd_data, exp_pos[15:8]);
    @(negedge clk) rd_n = 1'b1;

    // R8: asynchronous reset mid-run
    for (int i = 0; i < 2; i++) step(1'b1);
    @(negedge clk);
    rd_n = 1'b0; rd_sel = 1'b1;
    #0.5 rst_n = 1'b0;
    #0.5 check("R8 async clear", rd_data, 0);
    enc_a = 1'b0; enc_b = 1'b0; idx = 0; exp_pos = '0;
    @(negedge clk) rd_n = 1'b1;
    @(negedge clk) rst_n = 1'b1;
    expect_pos("R8 after reset");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule